// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

This block lets up to 32 requesting masters each signal a single receiving agent. A master rings by writing a word with bit 0 set to the trigger register; the master-ID input that comes with the write selects which bit position the ring affects. Every ring is recorded in a raw register. A ring also becomes a pending notification only when the receiver has set that master's bit in its enable mask.

The receiver services the unit through the same simple register port. It sets the enable mask. It reads the pending word and acknowledges it by writing the same value back, because writing a 1 clears that bit. A level interrupt stays high for as long as any pending bit is set. The raw register is also cleared by writing 1s, so the receiver can see rings that were refused by the mask.

Top module: `ring_hub`

## Requirements
- R1: After reset the enable, raw and pending words read as zero, the interrupt is low and the read data output is zero.
- R2: A write to the trigger register (address bits [3:2] = 0) whose data has bit 0 = 1 sets raw bit n, where n is the master-ID input, whatever the state of the enable mask.
- R3: That write sets pending bit n only when enable bit n is 1 at the time of the write. Otherwise the pending word is left unchanged.
- R4: A write to the trigger register whose data has bit 0 = 0 changes neither the raw word nor the pending word.
- R5: A write to the enable register (address bits [3:2] = 1) replaces all of its bits with the written data. The value reads back unchanged.
- R6: A write to the pending register (address bits [3:2] = 3) clears each pending bit whose data bit is 1 and keeps each bit whose data bit is 0.
- R7: A write to the raw register (address bits [3:2] = 2) clears raw bits in the same way, one for each data bit that is 1.
- R8: The interrupt output is high in every cycle in which at least one pending bit is set, and low otherwise. It follows the pending word from the same clock edge.
- R9: A read returns its data on the clock edge that samples the read strobe. The data holds until the next read. The trigger register reads as zero.
- R10: Changing the enable mask does not set or clear any pending bit that is already recorded.
- R11: An access whose address has a nonzero bit [1:0], or any nonzero bit above bit 3, is ignored when it is a write and returns zero when it is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_master_id | input | ID_W (5) | Identity of the master issuing the access |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while any pending bit is set |

## Verification
All state changes take effect at the clock edge that samples a write. The raw, pending and enable words, and the interrupt that follows the pending word, are therefore due one edge after the write strobe. Read data is also due one edge after the read strobe. The driver applies each access at a falling edge and removes it at the next falling edge, so a one-cycle result is already settled when irq is sampled there. Expected read words go into a queue when the read is issued. The monitor pops and compares one word at the falling edge after each sampled read strobe, so each comparison falls exactly on the cycle in which the data is due.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Register select, taken from address bits [3:2]
  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_EN   = 2'd1,
    REG_RAW  = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  // One sticky status bit: a set in the same cycle overrides a clear
  function automatic logic sticky_next(input logic cur, input logic set_i, input logic clr_i);
    return set_i | (cur & ~clr_i);
  endfunction

  // Address is decodable: word aligned and inside the 16-byte window
  function automatic logic addr_ok(input logic [1:0] low, input logic high_zero);
    return (low == 2'b00) && high_zero;
  endfunction

endpackage

// File: rtl/ring_decode.sv
module ring_decode
  import ring_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_M  = 32,
  parameter int ID_W   = 5
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wdata_bit0,
  input  logic [ID_W-1:0]   master_id,
  output logic              ring_hit,
  output logic [NUM_M-1:0]  ring_oh,
  output logic              wr_en,
  output logic              wr_raw,
  output logic              wr_pend,
  output logic              rd_ok,
  output reg_sel_e          sel
);

  logic aligned;
  logic id_ok;

  assign aligned = addr_ok(bus_addr[1:0], (bus_addr >> 4) == '0);
  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign id_ok   = int'(master_id) < NUM_M;

  assign ring_hit = bus_wr && aligned && (sel == REG_TRIG) && wdata_bit0 && id_ok;
  assign wr_en    = bus_wr && aligned && (sel == REG_EN);
  assign wr_raw   = bus_wr && aligned && (sel == REG_RAW);
  assign wr_pend  = bus_wr && aligned && (sel == REG_PEND);
  assign rd_ok    = bus_rd && aligned;

  for (genvar i = 0; i < NUM_M; i++) begin : g_oh
    assign ring_oh[i] = ring_hit && (master_id == ID_W'(i));
  end

endmodule

// File: rtl/ring_state.sv
module ring_state
  import ring_pkg::*;
#(
  parameter int NUM_M = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] ring_oh,
  input  logic             wr_en,
  input  logic             wr_raw,
  input  logic             wr_pend,
  input  logic [NUM_M-1:0] wdata,
  output logic [NUM_M-1:0] en_q,
  output logic [NUM_M-1:0] raw_q,
  output logic [NUM_M-1:0] pend_q
);

  for (genvar i = 0; i < NUM_M; i++) begin : g_bit
    logic set_pend;
    logic clr_raw;
    logic clr_pend;

    assign set_pend = ring_oh[i] & en_q[i];
    assign clr_raw  = wr_raw & wdata[i];
    assign clr_pend = wr_pend & wdata[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        raw_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr_en) en_q[i] <= wdata[i];
        raw_q[i]  <= sticky_next(raw_q[i], ring_oh[i], clr_raw);
        pend_q[i] <= sticky_next(pend_q[i], set_pend, clr_pend);
      end
    end
  end

endmodule

// File: rtl/ring_readout.sv
module ring_readout
  import ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_M  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              rd_ok,
  input  reg_sel_e          sel,
  input  logic [NUM_M-1:0]  en_q,
  input  logic [NUM_M-1:0]  raw_q,
  input  logic [NUM_M-1:0]  pend_q,
  output logic [DATA_W-1:0] rdata
);

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_M-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_M-1:0] = v;
    return r;
  endfunction

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    if (rd_ok) begin
      case (sel)
        REG_EN:   mux_d = widen(en_q);
        REG_RAW:  mux_d = widen(raw_q);
        REG_PEND: mux_d = widen(pend_q);
        default:  mux_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= mux_d;
  end

endmodule

// File: rtl/ring_hub.sv
module ring_hub
  import ring_pkg::*;
#(
  parameter int NUM_MASTERS = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ID_W-1:0]   bus_master_id,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic                   ring_hit;
  logic [NUM_MASTERS-1:0] ring_oh;
  logic                   wr_en;
  logic                   wr_raw;
  logic                   wr_pend;
  logic                   rd_ok;
  reg_sel_e               sel;
  logic [NUM_MASTERS-1:0] en_q;
  logic [NUM_MASTERS-1:0] raw_q;
  logic [NUM_MASTERS-1:0] pend_q;

  ring_decode #(.ADDR_W(ADDR_W), .NUM_M(NUM_MASTERS), .ID_W(ID_W)) u_dec (
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wdata_bit0 (bus_wdata[0]),
    .master_id  (bus_master_id),
    .ring_hit   (ring_hit),
    .ring_oh    (ring_oh),
    .wr_en      (wr_en),
    .wr_raw     (wr_raw),
    .wr_pend    (wr_pend),
    .rd_ok      (rd_ok),
    .sel        (sel)
  );

  ring_state #(.NUM_M(NUM_MASTERS)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .ring_oh (ring_oh),
    .wr_en   (wr_en),
    .wr_raw  (wr_raw),
    .wr_pend (wr_pend),
    .wdata   (bus_wdata[NUM_MASTERS-1:0]),
    .en_q    (en_q),
    .raw_q   (raw_q),
    .pend_q  (pend_q)
  );

  ring_readout #(.DATA_W(DATA_W), .NUM_M(NUM_MASTERS)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_rd (bus_rd),
    .rd_ok  (rd_ok),
    .sel    (sel),
    .en_q   (en_q),
    .raw_q  (raw_q),
    .pend_q (pend_q),
    .rdata  (bus_rdata)
  );

  assign irq = |pend_q;

endmodule

// File: rtl/ring_hub_chk.sv
module ring_hub_chk #(
  parameter int NUM_M  = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [ID_W-1:0]   bus_master_id,
  input logic              irq,
  input logic              ring_hit,
  input logic              wr_en,
  input logic              wr_pend,
  input logic [NUM_M-1:0]  en_q,
  input logic [NUM_M-1:0]  raw_q,
  input logic [NUM_M-1:0]  pend_q
);

  // R2: an accepted ring always leaves the ringing master's raw bit set
  p_raw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_hit |=> raw_q[$past(bus_master_id)]);

  // R3: a ring from a masked master does not create a pending bit
  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_hit && !en_q[bus_master_id] && !pend_q[bus_master_id])
      |=> !pend_q[$past(bus_master_id)]);

  // R8: an enabled ring raises the interrupt on the next edge
  p_irq_on_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_hit && en_q[bus_master_id]) |=> irq);

  // R6: written-one bits of the pending word are gone after the acknowledge
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !ring_hit) |=> ((pend_q & $past(bus_wdata[NUM_M-1:0])) == '0));

  // R10: an enable write alone never changes the pending word
  p_mask_keeps_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ring_hit && !wr_pend) |=> $stable(pend_q));

  // R4: a trigger write with bit 0 clear does not ring anything
  p_zero_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ring_hit && !wr_pend && !bus_wdata[0] && (pend_q == '0)) |=> !irq);

endmodule

bind ring_hub ring_hub_chk #(
  .NUM_M  (NUM_MASTERS),
  .DATA_W (DATA_W),
  .ID_W   (ID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_master_id (bus_master_id),
  .irq           (irq),
  .ring_hit      (ring_hit),
  .wr_en         (wr_en),
  .wr_pend       (wr_pend),
  .en_q          (en_q),
  .raw_q         (raw_q),
  .pend_q        (pend_q)
);

// File: tb/tb_ring_hub.sv
`timescale 1ns/1ps
module tb_ring_hub;

  localparam int NM = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [4:0]  bus_master_id = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  // independent model of the registers
  logic [31:0] m_en = '0, m_raw = '0, m_pend = '0;

  always #2 clk = ~clk;

  ring_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_master_id(bus_master_id),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares the queued expectation one edge after each read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read data", bus_rdata, 32'hx);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [4:0] id);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_master_id = id; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a[1:0] == 2'b00) begin
      case (a[3:2])
        2'd0: if (d[0]) begin
                m_raw[id] = 1'b1;
                if (m_en[id]) m_pend[id] = 1'b1;
              end
        2'd1: m_en = d;
        2'd2: m_raw = m_raw & ~d;
        default: m_pend = m_pend & ~d;
      endcase
    end
  endtask

  task automatic verify(input string tag);
    check({tag, " irq R8"}, {31'd0, irq}, {31'd0, m_pend != 0});
    bus_read(4'h4, m_en,   {tag, " enable"});
    bus_read(4'h8, m_raw,  {tag, " raw"});
    bus_read(4'hC, m_pend, {tag, " pending"});
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata at reset", bus_rdata, 32'h0);
    check("R1 irq at reset", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    verify("R1 reset state");

    bus_write(4'h4, 32'h0000_00A5, 5'd3);
    verify("R5 enable write");

    bus_write(4'h0, 32'h1, 5'd0);
    verify("R2 R3 enabled ring");
    check("R8 irq after enabled ring", {31'd0, irq}, 32'h1);

    bus_write(4'h0, 32'h1, 5'd1);
    verify("R3 masked ring");

    bus_write(4'h0, 32'hFFFF_FFFE, 5'd31);
    verify("R4 trigger bit0 clear");

    bus_read(4'h0, 32'h0, "R9 trigger reads zero");

    bus_write(4'h4, 32'h8000_0000, 5'd2);
    bus_write(4'h0, 32'h1, 5'd31);
    bus_write(4'h4, 32'h0, 5'd2);
    verify("R10 enable change keeps pending");

    bus_write(4'h2, 32'hFFFF_FFFF, 5'd0);
    bus_write(4'h9, 32'hFFFF_FFFF, 5'd0);
    verify("R11 misaligned write ignored");
    bus_read(4'hD, 32'h0, "R11 misaligned read zero");

    bus_write(4'hC, 32'h0000_0001, 5'd4);
    verify("R6 partial acknowledge");
    bus_write(4'hC, 32'h8000_0000, 5'd4);
    verify("R6 final acknowledge");
    check("R8 irq low when idle", {31'd0, irq}, 32'h0);

    bus_write(4'h8, 32'h0000_0002, 5'd4);
    verify("R7 raw clear");

    bus_write(4'h4, 32'hFFFF_FFFF, 5'd0);
    for (int i = 0; i < NM; i++) begin
      bus_write(4'h0, 32'h1, 5'(i));
      check("R3 R8 irq per master", {31'd0, irq}, 32'h1);
    end
    verify("R2 R3 all masters");
    bus_write(4'hC, m_pend, 5'd0);
    bus_write(4'h8, 32'hFFFF_FFFF, 5'd0);
    verify("R6 R7 read-back acknowledge");
    bus_read(4'h4, 32'hFFFF_FFFF, "R9 read data after read");
    repeat (2) @(negedge clk);
    check("R9 read data holds", bus_rdata, 32'hFFFF_FFFF);

    repeat (3) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule